// File: doc/BRIEF.md
# Bucketed Credit Receive Buffer

This block is the receive side of a station on a message ring. A single 256-entry message store is divided into as many as eight independent circular queues, called buckets. Each sender on the ring is addressed to a bucket, not to the station, and may only deliver a message while it holds credit for that bucket. Software sets a base index and a size for every bucket, along with a credit allowance for every pair of sender and bucket. It does this while the block is disabled, and then enables the block.

When the block is enabled, every credit counter is loaded from the programmed allowance table. Each accepted message uses up one credit. Each message popped by the local consumer gives one credit back to the sender that wrote it, so the sender identity is stored with every entry. A configuration checker watches the programmed geometry and allowances continuously, and the block refuses to start while any rule is broken. A write that cannot be accepted is dropped and recorded in a sticky flag.

Top module: `bucket_rx_store`

## Requirements
- R1: After reset the block is not running, `overflow` and `cfgErr` are 0, `rdValid` is 0 and `wrAccept` is 0 even with `wrValid` high. Every bucket has size 0 and every credit allowance is 0.
- R2: A configuration write (`cfgWe`) takes effect at the clock edge only while `enable` is low and the block is not running. While running, a configuration write changes nothing.
- R3: With `enable` high and `cfgErr` low, `running` goes to 1 at the next edge, and every credit counter is loaded from its programmed allowance. With `cfgErr` high, `running` stays 0.
- R4: `cfgErr` is 1 whenever any of these holds: a nonzero bucket size is not a power of two; a base is not a multiple of its nonzero size; base plus size exceeds 256; two nonzero buckets share an entry; the allowances toward a bucket sum to more than its size.
- R5: `wrAccept` is 1 exactly when `wrValid` is high, the block is running, the sender (`wrSnd`) has nonzero credit for bucket `wrBkt`, and that bucket is not full. An accepted write lowers that sender's credit for that bucket by one.
- R6: A bucket of size 0 accepts no message.
- R7: Each bucket is first-in first-out. With `rdBkt` selecting a bucket, `rdValid` shows that it is non-empty and `rdData`/`rdSnd` show its oldest entry. `rdReq` with `rdValid` high pops that entry. An empty bucket gives `rdValid` 0.
- R8: A pop returns one credit to the sender recorded with the popped entry, for that bucket.
- R9: The read and write positions of a bucket wrap inside that bucket's own region, so order is kept across the wrap and other buckets are untouched.
- R10: A write presented while running but not accepted sets `overflow`. The flag stays set until reset or the next start of running.
- R11: Lowering `enable` stops the block at the next edge and empties every bucket.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run request; low allows configuration |
| cfgWe | input | 1 | Configuration write strobe |
| cfgIsCredit | input | 1 | 1: write a credit allowance, 0: write bucket geometry |
| cfgBkt | input | 3 | Bucket index for the configuration write |
| cfgSnd | input | 3 | Sender index for a credit allowance write |
| cfgBase | input | 8 | Bucket base index (geometry writes) |
| cfgVal | input | 9 | Bucket size or credit allowance |
| wrValid | input | 1 | Incoming message present |
| wrSnd | input | 3 | Sender of the incoming message |
| wrBkt | input | 3 | Destination bucket of the incoming message |
| wrData | input | 32 | Message payload |
| wrAccept | output | 1 | Incoming message is taken this cycle |
| rdReq | input | 1 | Pop the head of the selected bucket |
| rdBkt | input | 3 | Bucket selected for reading |
| rdValid | output | 1 | Selected bucket holds a message |
| rdData | output | 32 | Payload at the head of the selected bucket |
| rdSnd | output | 3 | Sender recorded with that head entry |
| crdQSnd | input | 3 | Sender index for the credit view |
| crdQBkt | input | 3 | Bucket index for the credit view |
| crdLeft | output | 9 | Remaining credit of the viewed pair |
| running | output | 1 | Block is active |
| overflow | output | 1 | Sticky dropped-write flag |
| cfgErr | output | 1 | Programmed configuration breaks a rule |

## Verification
The properties assume that `rstN` is held low for the first edges and that `enable` is a level, not a glitch. They also take `rdReq` as meaningful only when `rdValid` is high, and configuration writes during running as stray traffic that must leave the checked configuration unchanged. The stimulus programs geometry and allowances only while the block is disabled, except for one deliberate configuration write while running. All indices stay within the eight buckets and eight senders. Every legal configuration keeps each bucket's allowance sum within its size, so a full bucket can only arise through that sum.

// File: rtl/bucket_rx_pkg.sv
package bucket_rx_pkg;
  // Strobes sent from the control side to the storage side each cycle.
  typedef struct packed {
    logic push;   // store the incoming message, spend one credit
    logic pop;    // drop the head of rdBkt, return its credit
    logic load;   // copy the allowance table into the credit counters
    logic flush;  // empty every bucket
  } rx_strobe_t;
endpackage

// File: rtl/bucket_rx_ctrl.sv
module bucket_rx_ctrl
  import bucket_rx_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int NB    = 8,
  parameter int NS    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int SZW  = AW + 1,
  localparam int BW   = $clog2(NB),
  localparam int SW   = $clog2(NS)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          enable,
  input  logic                          cfgWe,
  input  logic                          cfgIsCredit,
  input  logic [BW-1:0]                 cfgBkt,
  input  logic [SW-1:0]                 cfgSnd,
  input  logic [AW-1:0]                 cfgBase,
  input  logic [SZW-1:0]                cfgVal,
  input  logic                          wrValid,
  input  logic [SW-1:0]                 wrSnd,
  input  logic [BW-1:0]                 wrBkt,
  input  logic                          rdReq,
  input  logic [BW-1:0]                 rdBkt,
  input  logic [NB-1:0]                 bktFull,
  input  logic [NB-1:0]                 bktEmpty,
  input  logic [NS-1:0][NB-1:0]         crdAvail,
  output rx_strobe_t                    strb,
  output logic [NB-1:0][AW-1:0]         bktBase,
  output logic [NB-1:0][SZW-1:0]        bktSize,
  output logic [NS-1:0][NB-1:0][SZW-1:0] crdTbl,
  output logic                          running,
  output logic                          wrAccept,
  output logic                          rdValid,
  output logic                          overflow,
  output logic                          cfgErr
);
  localparam int EW  = SZW + 1;
  localparam int CSW = SZW + SW + 1;

  logic cfgOpen;
  logic startNow;
  logic [NB-1:0][EW-1:0] loEdge;
  logic [NB-1:0][EW-1:0] hiEdge;
  logic [CSW-1:0] crdSum;
  logic errFlag;

  assign cfgOpen = !enable && !running;

  // Configuration registers: geometry per bucket, allowance per pair.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bktBase <= '0;
      bktSize <= '0;
      crdTbl  <= '0;
    end else if (cfgWe && cfgOpen) begin
      if (cfgIsCredit) begin
        crdTbl[cfgSnd][cfgBkt] <= cfgVal;
      end else begin
        bktBase[cfgBkt] <= cfgBase;
        bktSize[cfgBkt] <= cfgVal;
      end
    end
  end

  // Rule checker over the programmed configuration.
  always_comb begin
    errFlag = 1'b0;
    crdSum  = '0;
    for (int b = 0; b < NB; b++) begin
      loEdge[b] = EW'(bktBase[b]);
      hiEdge[b] = EW'(bktBase[b]) + EW'(bktSize[b]);
    end
    for (int b = 0; b < NB; b++) begin
      crdSum = '0;
      for (int s = 0; s < NS; s++) begin
        crdSum = crdSum + CSW'(crdTbl[s][b]);
      end
      if (crdSum > CSW'(bktSize[b])) errFlag = 1'b1;
      if (bktSize[b] != '0) begin
        if ((bktSize[b] & (bktSize[b] - 1'b1)) != '0) errFlag = 1'b1;
        if ((SZW'(bktBase[b]) & (bktSize[b] - 1'b1)) != '0) errFlag = 1'b1;
        if (hiEdge[b] > EW'(DEPTH)) errFlag = 1'b1;
      end
    end
    for (int i = 0; i < NB; i++) begin
      for (int j = i + 1; j < NB; j++) begin
        if (bktSize[i] != '0 && bktSize[j] != '0 &&
            loEdge[i] < hiEdge[j] && loEdge[j] < hiEdge[i]) begin
          errFlag = 1'b1;
        end
      end
    end
  end

  assign cfgErr   = errFlag;
  assign startNow = enable && !running && !cfgErr;

  always_ff @(posedge clk) begin
    if (!rstN) running <= 1'b0;
    else       running <= enable && (running || !cfgErr);
  end

  assign wrAccept = wrValid && running && crdAvail[wrSnd][wrBkt] && !bktFull[wrBkt];
  assign rdValid  = running && !bktEmpty[rdBkt];

  always_ff @(posedge clk) begin
    if (!rstN)                              overflow <= 1'b0;
    else if (startNow)                      overflow <= 1'b0;
    else if (wrValid && running && !wrAccept) overflow <= 1'b1;
  end

  always_comb begin
    strb.push  = wrAccept;
    strb.pop   = rdReq && rdValid;
    strb.load  = startNow;
    strb.flush = !running;
  end
endmodule

// File: rtl/bucket_rx_data.sv
module bucket_rx_data
  import bucket_rx_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int NB    = 8,
  parameter int NS    = 8,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int SZW  = AW + 1,
  localparam int BW   = $clog2(NB),
  localparam int SW   = $clog2(NS)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  rx_strobe_t                     strb,
  input  logic [SW-1:0]                  wrSnd,
  input  logic [BW-1:0]                  wrBkt,
  input  logic [DW-1:0]                  wrData,
  input  logic [BW-1:0]                  rdBkt,
  input  logic [NB-1:0][AW-1:0]          bktBase,
  input  logic [NB-1:0][SZW-1:0]         bktSize,
  input  logic [NS-1:0][NB-1:0][SZW-1:0] crdTbl,
  input  logic [SW-1:0]                  crdQSnd,
  input  logic [BW-1:0]                  crdQBkt,
  output logic [NB-1:0]                  bktFull,
  output logic [NB-1:0]                  bktEmpty,
  output logic [NS-1:0][NB-1:0]          crdAvail,
  output logic [DW-1:0]                  rdData,
  output logic [SW-1:0]                  rdSnd,
  output logic [SZW-1:0]                 crdLeft
);
  logic [SW+DW-1:0] store [DEPTH];
  logic [NB-1:0][AW-1:0]          wrOff;
  logic [NB-1:0][AW-1:0]          rdOff;
  logic [NB-1:0][SZW-1:0]         fill;
  logic [NS-1:0][NB-1:0][SZW-1:0] crd;
  logic [AW-1:0]    wrAddr;
  logic [AW-1:0]    rdAddr;
  logic [SW+DW-1:0] headEntry;

  // Bases are aligned to their sizes, so base + offset never carries out.
  assign wrAddr    = bktBase[wrBkt] + wrOff[wrBkt];
  assign rdAddr    = bktBase[rdBkt] + rdOff[rdBkt];
  assign headEntry = store[rdAddr];
  assign rdData    = headEntry[DW-1:0];
  assign rdSnd     = headEntry[DW +: SW];
  assign crdLeft   = crd[crdQSnd][crdQBkt];

  always_ff @(posedge clk) begin
    if (strb.push) store[wrAddr] <= {wrSnd, wrData};
  end

  for (genvar b = 0; b < NB; b++) begin : g_bkt
    logic pushHere;
    logic popHere;
    logic [AW-1:0] wrNext;
    logic [AW-1:0] rdNext;

    assign pushHere = strb.push && (wrBkt == BW'(b));
    assign popHere  = strb.pop  && (rdBkt == BW'(b));
    assign wrNext   = (SZW'(wrOff[b]) + SZW'(1) == bktSize[b]) ? '0 : wrOff[b] + 1'b1;
    assign rdNext   = (SZW'(rdOff[b]) + SZW'(1) == bktSize[b]) ? '0 : rdOff[b] + 1'b1;
    assign bktFull[b]  = (fill[b] == bktSize[b]);
    assign bktEmpty[b] = (fill[b] == '0);

    always_ff @(posedge clk) begin
      if (!rstN || strb.flush) begin
        wrOff[b] <= '0;
        rdOff[b] <= '0;
        fill[b]  <= '0;
      end else begin
        if (pushHere) wrOff[b] <= wrNext;
        if (popHere)  rdOff[b] <= rdNext;
        case ({pushHere, popHere})
          2'b10:   fill[b] <= fill[b] + 1'b1;
          2'b01:   fill[b] <= fill[b] - 1'b1;
          default: fill[b] <= fill[b];
        endcase
      end
    end
  end

  for (genvar s = 0; s < NS; s++) begin : g_snd
    for (genvar b = 0; b < NB; b++) begin : g_pair
      logic spend;
      logic refund;
      assign spend  = strb.push && (wrSnd == SW'(s)) && (wrBkt == BW'(b));
      assign refund = strb.pop  && (rdSnd == SW'(s)) && (rdBkt == BW'(b));
      assign crdAvail[s][b] = (crd[s][b] != '0);

      always_ff @(posedge clk) begin
        if (!rstN)          crd[s][b] <= '0;
        else if (strb.load) crd[s][b] <= crdTbl[s][b];
        else                crd[s][b] <= crd[s][b] - SZW'(spend) + SZW'(refund);
      end
    end
  end
endmodule

// File: rtl/bucket_rx_store.sv
module bucket_rx_store
  import bucket_rx_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int NB    = 8,
  parameter int NS    = 8,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int SZW  = AW + 1,
  localparam int BW   = $clog2(NB),
  localparam int SW   = $clog2(NS)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           enable,
  input  logic           cfgWe,
  input  logic           cfgIsCredit,
  input  logic [BW-1:0]  cfgBkt,
  input  logic [SW-1:0]  cfgSnd,
  input  logic [AW-1:0]  cfgBase,
  input  logic [SZW-1:0] cfgVal,
  input  logic           wrValid,
  input  logic [SW-1:0]  wrSnd,
  input  logic [BW-1:0]  wrBkt,
  input  logic [DW-1:0]  wrData,
  output logic           wrAccept,
  input  logic           rdReq,
  input  logic [BW-1:0]  rdBkt,
  output logic           rdValid,
  output logic [DW-1:0]  rdData,
  output logic [SW-1:0]  rdSnd,
  input  logic [SW-1:0]  crdQSnd,
  input  logic [BW-1:0]  crdQBkt,
  output logic [SZW-1:0] crdLeft,
  output logic           running,
  output logic           overflow,
  output logic           cfgErr
);
  rx_strobe_t                     strb;
  logic [NB-1:0][AW-1:0]          bktBase;
  logic [NB-1:0][SZW-1:0]         bktSize;
  logic [NS-1:0][NB-1:0][SZW-1:0] crdTbl;
  logic [NB-1:0]                  bktFull;
  logic [NB-1:0]                  bktEmpty;
  logic [NS-1:0][NB-1:0]          crdAvail;

  bucket_rx_ctrl #(.DEPTH(DEPTH), .NB(NB), .NS(NS)) ctrl_i (
    .clk(clk), .rstN(rstN), .enable(enable),
    .cfgWe(cfgWe), .cfgIsCredit(cfgIsCredit), .cfgBkt(cfgBkt), .cfgSnd(cfgSnd),
    .cfgBase(cfgBase), .cfgVal(cfgVal),
    .wrValid(wrValid), .wrSnd(wrSnd), .wrBkt(wrBkt),
    .rdReq(rdReq), .rdBkt(rdBkt),
    .bktFull(bktFull), .bktEmpty(bktEmpty), .crdAvail(crdAvail),
    .strb(strb), .bktBase(bktBase), .bktSize(bktSize), .crdTbl(crdTbl),
    .running(running), .wrAccept(wrAccept), .rdValid(rdValid),
    .overflow(overflow), .cfgErr(cfgErr)
  );

  bucket_rx_data #(.DEPTH(DEPTH), .NB(NB), .NS(NS), .DW(DW)) data_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrSnd(wrSnd), .wrBkt(wrBkt), .wrData(wrData), .rdBkt(rdBkt),
    .bktBase(bktBase), .bktSize(bktSize), .crdTbl(crdTbl),
    .crdQSnd(crdQSnd), .crdQBkt(crdQBkt),
    .bktFull(bktFull), .bktEmpty(bktEmpty), .crdAvail(crdAvail),
    .rdData(rdData), .rdSnd(rdSnd), .crdLeft(crdLeft)
  );
endmodule

// File: rtl/bucket_rx_store_chk.sv
module bucket_rx_store_chk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic cfgWe,
  input logic cfgErr,
  input logic running,
  input logic wrAccept,
  input logic rdValid,
  input logic overflow
);
  // R5
  accept_needs_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrAccept |-> running);

  // R7
  read_needs_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> running);

  // R2
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && cfgWe) |=> $stable(cfgErr));

  // R3
  start_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(running) |-> ($past(enable) && !$past(cfgErr)));

  // R10
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && running) |=> overflow);

  // R11
  stop_on_disable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !running);
endmodule

bind bucket_rx_store bucket_rx_store_chk chk_i (
  .clk(clk), .rstN(rstN), .enable(enable), .cfgWe(cfgWe), .cfgErr(cfgErr),
  .running(running), .wrAccept(wrAccept), .rdValid(rdValid), .overflow(overflow)
);

// File: tb/bucket_rx_store_tb_top.sv
module bucket_rx_store_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        cfgWe = 1'b0;
  logic        cfgIsCredit = 1'b0;
  logic [2:0]  cfgBkt = '0;
  logic [2:0]  cfgSnd = '0;
  logic [7:0]  cfgBase = '0;
  logic [8:0]  cfgVal = '0;
  logic        wrValid = 1'b0;
  logic [2:0]  wrSnd = '0;
  logic [2:0]  wrBkt = '0;
  logic [31:0] wrData = '0;
  logic        wrAccept;
  logic        rdReq = 1'b0;
  logic [2:0]  rdBkt = '0;
  logic        rdValid;
  logic [31:0] rdData;
  logic [2:0]  rdSnd;
  logic [2:0]  crdQSnd = '0;
  logic [2:0]  crdQBkt = '0;
  logic [8:0]  crdLeft;
  logic        running;
  logic        overflow;
  logic        cfgErr;

  int total = 0;
  int passed = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bucket_rx_store dut_i (.*);

  typedef struct packed {
    logic [1:0]  op;     // 0 write, 1 read/pop, 2 credit view
    logic [2:0]  snd;
    logic [2:0]  bkt;
    logic [31:0] dat;    // payload, or expected head payload
    logic        expOk;  // expected wrAccept / rdValid
    logic [2:0]  expSnd;
    logic [8:0]  expCrd;
  } vec_t;

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_CQ = 2'd2;

  localparam vec_t VECS [0:23] = '{
    '{OP_WR, 3'd1, 3'd0, 32'hA1, 1'b1, 3'd0, 9'd0},  // R5
    '{OP_WR, 3'd1, 3'd0, 32'hA2, 1'b1, 3'd0, 9'd0},  // R5
    '{OP_WR, 3'd1, 3'd0, 32'hA3, 1'b1, 3'd0, 9'd0},  // R5
    '{OP_CQ, 3'd1, 3'd0, 32'h0,  1'b0, 3'd0, 9'd0},  // R5 credit spent
    '{OP_WR, 3'd1, 3'd0, 32'hA4, 1'b0, 3'd0, 9'd0},  // R5 zero credit
    '{OP_WR, 3'd2, 3'd0, 32'hB1, 1'b1, 3'd0, 9'd0},  // R5 bucket now full
    '{OP_WR, 3'd0, 3'd3, 32'hC1, 1'b0, 3'd0, 9'd0},  // R6 size zero
    '{OP_RD, 3'd0, 3'd0, 32'hA1, 1'b1, 3'd1, 9'd0},  // R7
    '{OP_WR, 3'd1, 3'd0, 32'hA5, 1'b1, 3'd0, 9'd0},  // R8 refunded credit, R9 wraps
    '{OP_RD, 3'd0, 3'd0, 32'hA2, 1'b1, 3'd1, 9'd0},  // R7
    '{OP_RD, 3'd0, 3'd0, 32'hA3, 1'b1, 3'd1, 9'd0},  // R7
    '{OP_RD, 3'd0, 3'd0, 32'hB1, 1'b1, 3'd2, 9'd0},  // R7
    '{OP_RD, 3'd0, 3'd0, 32'hA5, 1'b1, 3'd1, 9'd0},  // R9 wrapped entry
    '{OP_RD, 3'd0, 3'd0, 32'h0,  1'b0, 3'd0, 9'd0},  // R7 empty
    '{OP_WR, 3'd2, 3'd0, 32'hB2, 1'b1, 3'd0, 9'd0},  // R8
    '{OP_RD, 3'd0, 3'd0, 32'hB2, 1'b1, 3'd2, 9'd0},  // R7
    '{OP_WR, 3'd0, 3'd1, 32'hD1, 1'b1, 3'd0, 9'd0},  // R5
    '{OP_RD, 3'd0, 3'd2, 32'h0,  1'b0, 3'd0, 9'd0},  // R9 neighbour untouched
    '{OP_RD, 3'd0, 3'd1, 32'hD1, 1'b1, 3'd0, 9'd0},  // R7
    '{OP_WR, 3'd3, 3'd2, 32'hE1, 1'b1, 3'd0, 9'd0},  // R5
    '{OP_RD, 3'd0, 3'd2, 32'hE1, 1'b1, 3'd3, 9'd0},  // R7
    '{OP_CQ, 3'd1, 3'd0, 32'h0,  1'b0, 3'd0, 9'd3},  // R8
    '{OP_CQ, 3'd2, 3'd0, 32'h0,  1'b0, 3'd0, 9'd1},  // R8
    '{OP_CQ, 3'd3, 3'd2, 32'h0,  1'b0, 3'd0, 9'd8}   // R8
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (ok) passed++;
    else $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
  endtask

  task automatic cfgGeo(input int b, input int base, input int size);
    @(negedge clk);
    cfgWe = 1'b1; cfgIsCredit = 1'b0; cfgBkt = 3'(b); cfgBase = 8'(base); cfgVal = 9'(size);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic cfgCrd(input int s, input int b, input int v);
    @(negedge clk);
    cfgWe = 1'b1; cfgIsCredit = 1'b1; cfgSnd = 3'(s); cfgBkt = 3'(b); cfgVal = 9'(v);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic setEnable(input bit en);
    @(negedge clk);
    enable = en;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", passed, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    wrValid = 1'b1; wrSnd = 3'd0; wrBkt = 3'd0;
    #2;
    // R1 reset state
    check(!running, "R1 running", 32'(running), 0);
    check(!overflow && !cfgErr, "R1 flags", {overflow, cfgErr}, 0);
    check(!rdValid && !wrAccept, "R1 idle", {rdValid, wrAccept}, 0);
    @(negedge clk);
    wrValid = 1'b0;
    check(!overflow, "R1 no flag while stopped", 32'(overflow), 0);

    // R4 rule violations
    cfgGeo(0, 0, 3);
    check(cfgErr, "R4 size not power of two", 32'(cfgErr), 1);
    cfgGeo(0, 2, 4);
    check(cfgErr, "R4 misaligned base", 32'(cfgErr), 1);
    cfgGeo(0, 0, 4);
    check(!cfgErr, "R4 legal geometry", 32'(cfgErr), 0);
    cfgGeo(1, 2, 2);
    check(cfgErr, "R4 overlap", 32'(cfgErr), 1);
    cfgGeo(1, 4, 4);
    cfgCrd(0, 0, 5);
    check(cfgErr, "R4 credit sum above size", 32'(cfgErr), 1);

    // R3 refuses to start with a bad configuration
    setEnable(1'b1);
    @(negedge clk);
    check(!running, "R3 blocked start", 32'(running), 0);
    setEnable(1'b0);

    cfgCrd(0, 0, 0);
    cfgGeo(2, 8, 8);
    cfgCrd(1, 0, 3);
    cfgCrd(2, 0, 1);
    cfgCrd(0, 1, 4);
    cfgCrd(3, 2, 8);
    check(!cfgErr, "R2 writes taken while stopped", 32'(cfgErr), 0);

    setEnable(1'b1);
    check(running, "R3 start", 32'(running), 1);
    crdQSnd = 3'd1; crdQBkt = 3'd0;
    #1;
    check(crdLeft == 9'd3, "R3 credit load", 32'(crdLeft), 3);

    // R2 configuration write while running has no effect
    cfgGeo(0, 0, 3);
    check(!cfgErr, "R2 write ignored while running", 32'(cfgErr), 0);

    foreach (VECS[i]) begin
      @(negedge clk);
      wrValid = (VECS[i].op == OP_WR);
      rdReq   = (VECS[i].op == OP_RD);
      wrSnd   = VECS[i].snd; wrBkt = VECS[i].bkt; wrData = VECS[i].dat;
      rdBkt   = VECS[i].bkt;
      crdQSnd = VECS[i].snd; crdQBkt = VECS[i].bkt;
      #2;
      case (VECS[i].op)
        OP_WR: check(wrAccept == VECS[i].expOk, $sformatf("R5 vector %0d accept", i),
                     32'(wrAccept), 32'(VECS[i].expOk));
        OP_RD: begin
          check(rdValid == VECS[i].expOk, $sformatf("R7 vector %0d valid", i),
                32'(rdValid), 32'(VECS[i].expOk));
          if (VECS[i].expOk) begin
            check(rdData == VECS[i].dat, $sformatf("R7 vector %0d data", i), rdData, VECS[i].dat);
            check(rdSnd == VECS[i].expSnd, $sformatf("R8 vector %0d sender", i),
                  32'(rdSnd), 32'(VECS[i].expSnd));
          end
        end
        default: check(crdLeft == VECS[i].expCrd, $sformatf("R8 vector %0d credit", i),
                       32'(crdLeft), 32'(VECS[i].expCrd));
      endcase
    end
    @(negedge clk);
    wrValid = 1'b0; rdReq = 1'b0;
    check(overflow, "R10 sticky after drops", 32'(overflow), 1);

    // R11 disable flushes; R10 cleared on restart; R3 credits reloaded
    wrValid = 1'b1; wrSnd = 3'd0; wrBkt = 3'd1; wrData = 32'hF1;
    @(negedge clk);
    wrValid = 1'b0;
    rdBkt = 3'd1;
    #1;
    check(rdValid, "R7 entry present before stop", 32'(rdValid), 1);
    setEnable(1'b0);
    check(!running, "R11 stopped", 32'(running), 0);
    check(overflow, "R10 held while stopped", 32'(overflow), 1);
    setEnable(1'b1);
    rdBkt = 3'd1; crdQSnd = 3'd0; crdQBkt = 3'd1;
    #1;
    check(running && !rdValid, "R11 bucket emptied", {running, rdValid}, 32'h2);
    check(!overflow, "R10 cleared on restart", 32'(overflow), 0);
    check(crdLeft == 9'd4, "R3 credit reload", 32'(crdLeft), 4);

    finished = 1'b1;
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end
endmodule